// File: doc/BRIEF.md
# Sectored Flash Command Interpreter

This block models a small sectored flash memory behind a 16-bit bus slave that speaks a command language. Every host write is taken either as a command byte or as the data phase of a two-write sequence. The commands cover sector erase, halfword program, setting and clearing a per-sector lock bit, status clear, and choosing what host reads return: array contents, the status byte, or the lock mask. The array is a register file that stands in for two banks of sectors. The sizes are parameters, so a simulation can use small sectors.

Erase, program and lock changes that are accepted hold the device busy for a fixed number of cycles, set by a parameter. While it is busy, the ready bit in the status byte reads 0 and any host write is dropped. Software waits by polling the status byte until the ready bit comes back. Error bits in the status byte stay set until software clears them.

Addresses are halfword addresses. Bank 0 comes first, with `BANK0_SECTORS` sectors of `SEC0_WORDS` halfwords each. Bank 1 follows at once, with `BANK1_SECTORS` sectors of `SEC1_WORDS` halfwords each. An address past the end of bank 1 belongs to no sector. Commands are decoded from `wrData[7:0]`.

Top module: `flash_cmd_unit`

## Requirements
- R1: After reset every halfword reads 0xFFFF, the read mode is array, the lock mask is 0, and the status byte reads 0x80.
- R2: Writing 0x20 and then 0xD0 to an address in an unlocked sector sets every halfword of that sector to 0xFFFF. Every other sector keeps its contents.
- R3: Writing 0x40 and then a data halfword to an address in an unlocked sector stores the old value AND the data. If the stored value differs from the data, status bit 4 (0x10) is set.
- R4: Writing 0x60 and then 0x01 to a sector address sets that sector's lock bit, and 0x60 then 0xD0 clears it. Mask bit i belongs to sector i: bank 0 sectors use bits 0..7 and bank 1 sectors use bits 8..11. Any other second byte changes nothing.
- R5: An erase confirm or program data write aimed at a locked sector, or at an address outside all sectors, sets status bit 1 (0x02). It changes no halfword and does not make the device busy.
- R6: After 0x20, a second write whose low byte is not 0xD0 sets status bit 5 (0x20), erases nothing and ends the sequence.
- R7: Command 0x70 selects status reads, which return {8'h00, status}. Command 0x90 selects mask reads, which return the mask zero-extended. Command 0xFF selects array reads. The second write of any two-write sequence also selects status reads.
- R8: Command 0x50 clears status bits 1, 4 and 5. Until then those bits stay set. Status bits other than 1, 4, 5 and 7 always read 0.
- R9: An accepted erase, program or lock change holds status bit 7 at 0 for BUSY_CYCLES cycles. Host writes made during that time have no effect.
- R10: `rdData` is registered: it takes the new value on the clock edge where `rdEn` is sampled high, and holds it otherwise. An array read outside all sectors returns 0. A first write with a low byte that is not a known command has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| addr | input | ADDR_W | Halfword address |
| wrData | input | 16 | Command byte (low 8 bits) or program data |
| rdData | output | 16 | Registered read data |

## Verification
Several properties are checked on every cycle by the assertions. The busy counter runs down one step per cycle, and a write during busy leaves the command phase and read mode unchanged. A program only ever clears bits, and an erase leaves the addressed word at all ones. No array update is issued to a locked or unmapped sector. At most one operation strobe fires at a time. A status clear empties the error bits.

Some results only show at the ports, and the bench's scenarios exercise them against its own model of the command language. These include whether a whole sector was erased while its neighbours were untouched, the exact mask layout, the sticky error bits across long random sequences, the read-mode switches and the registered read latency.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int HALF_W = 16;
  localparam int CMD_W  = 8;

  localparam logic [CMD_W-1:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [CMD_W-1:0] OP_PROG_SETUP  = 8'h40;
  localparam logic [CMD_W-1:0] OP_CLEAR_ERR   = 8'h50;
  localparam logic [CMD_W-1:0] OP_LOCK_SETUP  = 8'h60;
  localparam logic [CMD_W-1:0] OP_SHOW_STATUS = 8'h70;
  localparam logic [CMD_W-1:0] OP_SHOW_MASK   = 8'h90;
  localparam logic [CMD_W-1:0] OP_SHOW_ARRAY  = 8'hFF;
  localparam logic [CMD_W-1:0] OP_CONFIRM     = 8'hD0;
  localparam logic [CMD_W-1:0] OP_LOCK_ON     = 8'h01;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_MASK} rdMode_t;
  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_PROG, PH_LOCK} cmdPhase_t;

  typedef struct packed {
    logic doErase;
    logic doProg;
    logic doLockSet;
    logic doLockClr;
    logic setLockErr;
    logic setSeqErr;
    logic clrErr;
  } dpStrobe_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             secValid,
  input  logic             secLocked,
  output dpStrobe_t        strb,
  output rdMode_t          rdMode,
  output logic             ready
);

  localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES + 1);

  cmdPhase_t        phase, phaseNext;
  rdMode_t          modeNext;
  logic [CNT_W-1:0] busyCnt;
  logic             startBusy;
  logic             accept;

  assign ready  = (busyCnt == '0);
  assign accept = wrEn && ready;

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    modeNext  = rdMode;
    startBusy = 1'b0;
    if (accept) begin
      if (phase == PH_IDLE) begin
        case (cmdByte)
          OP_ERASE_SETUP: phaseNext = PH_ERASE;
          OP_PROG_SETUP:  phaseNext = PH_PROG;
          OP_LOCK_SETUP:  phaseNext = PH_LOCK;
          OP_SHOW_STATUS: modeNext  = RD_STATUS;
          OP_SHOW_MASK:   modeNext  = RD_MASK;
          OP_SHOW_ARRAY:  modeNext  = RD_ARRAY;
          OP_CLEAR_ERR:   strb.clrErr = 1'b1;
          default: ;
        endcase
      end else begin
        phaseNext = PH_IDLE;
        modeNext  = RD_STATUS;
        case (phase)
          PH_ERASE: begin
            if (cmdByte != OP_CONFIRM) begin
              strb.setSeqErr = 1'b1;
            end else if (!secValid || secLocked) begin
              strb.setLockErr = 1'b1;
            end else begin
              strb.doErase = 1'b1;
              startBusy    = 1'b1;
            end
          end
          PH_PROG: begin
            if (!secValid || secLocked) begin
              strb.setLockErr = 1'b1;
            end else begin
              strb.doProg = 1'b1;
              startBusy   = 1'b1;
            end
          end
          PH_LOCK: begin
            if (secValid && cmdByte == OP_LOCK_ON) begin
              strb.doLockSet = 1'b1;
              startBusy      = 1'b1;
            end else if (secValid && cmdByte == OP_CONFIRM) begin
              strb.doLockClr = 1'b1;
              startBusy      = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      rdMode  <= RD_ARRAY;
      busyCnt <= '0;
    end else begin
      phase  <= phaseNext;
      rdMode <= modeNext;
      if (startBusy) begin
        busyCnt <= CNT_W'(BUSY_CYCLES);
      end else if (!ready) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  // R9: a write while busy leaves the sequence state and read mode alone
  a_r9_busy_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !ready) |=> ($stable(phase) && $stable(rdMode)));

  // R9: the busy window shrinks by exactly one each cycle
  a_r9_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (!ready) |=> (busyCnt == $past(busyCnt) - 1'b1));

  // R9: never more than one array or lock operation per cycle
  a_r9_single_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doErase, strb.doProg, strb.doLockSet, strb.doLockClr}));

  // R7: finishing a two-write sequence lands in status read mode
  a_r7_status_after_second: assert property (@(posedge clk) disable iff (!rstN)
    (accept && phase != PH_IDLE) |=> (rdMode == RD_STATUS));

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int SEC0_WORDS    = 8,
  parameter int SEC1_WORDS    = 4,
  parameter int BANK0_SECTORS = 8,
  parameter int BANK1_SECTORS = 4,
  parameter int ADDR_W        = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wrData,
  input  dpStrobe_t         strb,
  input  rdMode_t           rdMode,
  input  logic              ready,
  output logic              secValid,
  output logic              secLocked,
  output logic [HALF_W-1:0] rdData
);

  localparam int NUM_SEC     = BANK0_SECTORS + BANK1_SECTORS;
  localparam int SEC_W       = $clog2(NUM_SEC);
  localparam int B0_WORDS    = BANK0_SECTORS * SEC0_WORDS;
  localparam int TOTAL_WORDS = B0_WORDS + BANK1_SECTORS * SEC1_WORDS;

  logic [HALF_W-1:0]  mem [TOTAL_WORDS];
  logic [NUM_SEC-1:0] lockMask;
  logic               errLock, errProg, errErase;
  logic [SEC_W-1:0]   secIdx;
  logic [HALF_W-1:0]  progVal;
  logic [7:0]         statusByte;
  logic [HALF_W-1:0]  rdNext;

  function automatic int wordSector(input int w);
    if (w < B0_WORDS) return w / SEC0_WORDS;
    return BANK0_SECTORS + (w - B0_WORDS) / SEC1_WORDS;
  endfunction

  always_comb begin
    secValid = 1'b1;
    secIdx   = '0;
    if (int'(addr) < B0_WORDS) begin
      secIdx = SEC_W'(int'(addr) / SEC0_WORDS);
    end else if (int'(addr) < TOTAL_WORDS) begin
      secIdx = SEC_W'(BANK0_SECTORS + (int'(addr) - B0_WORDS) / SEC1_WORDS);
    end else begin
      secValid = 1'b0;
    end
  end

  assign secLocked  = secValid && lockMask[secIdx];
  assign progVal    = mem[addr] & wrData;
  assign statusByte = {ready, 1'b0, errErase, errProg, 2'b00, errLock, 1'b0};

  always_comb begin
    case (rdMode)
      RD_STATUS: rdNext = {{(HALF_W-8){1'b0}}, statusByte};
      RD_MASK:   rdNext = HALF_W'(lockMask);
      default:   rdNext = secValid ? mem[addr] : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < TOTAL_WORDS; w++) mem[w] <= '1;
      lockMask <= '0;
      errLock  <= 1'b0;
      errProg  <= 1'b0;
      errErase <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strb.doErase) begin
        for (int w = 0; w < TOTAL_WORDS; w++) begin
          if (wordSector(w) == int'(secIdx)) mem[w] <= '1;
        end
      end
      if (strb.doProg) begin
        mem[addr] <= progVal;
        if (progVal != wrData) errProg <= 1'b1;
      end
      if (strb.doLockSet) lockMask[secIdx] <= 1'b1;
      if (strb.doLockClr) lockMask[secIdx] <= 1'b0;
      if (strb.setLockErr) errLock <= 1'b1;
      if (strb.setSeqErr) errErase <= 1'b1;
      if (strb.clrErr) begin
        errLock  <= 1'b0;
        errProg  <= 1'b0;
        errErase <= 1'b0;
      end
      if (rdEn) rdData <= rdNext;
    end
  end

  // R5: the control never updates the array of a locked or unmapped sector
  a_r5_no_update_locked: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doProg || strb.doErase) |-> (secValid && !lockMask[secIdx]));

  // R3: programming can only clear bits
  a_r3_and_only: assert property (@(posedge clk) disable iff (!rstN)
    strb.doProg |=> (mem[$past(addr)] == ($past(mem[addr]) & $past(wrData))));

  // R2: an erased sector holds all ones at the addressed word
  a_r2_erase_ones: assert property (@(posedge clk) disable iff (!rstN)
    strb.doErase |=> (mem[$past(addr)] == '1));

  // R8: a status clear empties every error bit
  a_r8_clear_errors: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrErr |=> !(errLock || errProg || errErase));

endmodule

// File: rtl/flash_cmd_unit.sv
module flash_cmd_unit
  import flash_cmd_pkg::*;
#(
  parameter int SEC0_WORDS    = 8,
  parameter int SEC1_WORDS    = 4,
  parameter int BANK0_SECTORS = 8,
  parameter int BANK1_SECTORS = 4,
  parameter int BUSY_CYCLES   = 6,
  localparam int ADDR_W = $clog2(BANK0_SECTORS * SEC0_WORDS + BANK1_SECTORS * SEC1_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] rdData
);

  dpStrobe_t strb;
  rdMode_t   rdMode;
  logic      ready;
  logic      secValid;
  logic      secLocked;

  flash_cmd_ctrl #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .cmdByte  (wrData[CMD_W-1:0]),
    .secValid (secValid),
    .secLocked(secLocked),
    .strb     (strb),
    .rdMode   (rdMode),
    .ready    (ready)
  );

  flash_cmd_dp #(
    .SEC0_WORDS   (SEC0_WORDS),
    .SEC1_WORDS   (SEC1_WORDS),
    .BANK0_SECTORS(BANK0_SECTORS),
    .BANK1_SECTORS(BANK1_SECTORS),
    .ADDR_W       (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rdEn     (rdEn),
    .addr     (addr),
    .wrData   (wrData),
    .strb     (strb),
    .rdMode   (rdMode),
    .ready    (ready),
    .secValid (secValid),
    .secLocked(secLocked),
    .rdData   (rdData)
  );

endmodule

// File: tb/flash_cmd_unit_bench.sv
`timescale 1ns/1ps
module flash_cmd_unit_bench;

  localparam int BUSY_CYCLES = 6;
  localparam int ADDR_W      = 7;
  localparam int TOTAL       = 80;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wrData = '0;
  logic [15:0]       rdData;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  logic [15:0] mArr [TOTAL];
  logic [11:0] mMask;
  logic [7:0]  mErr;
  int          mMode;
  int          mPhase;

  always #4 clk = ~clk;

  flash_cmd_unit #(.BUSY_CYCLES(BUSY_CYCLES)) u_flash_cmd_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  function automatic int secOf(input int a);
    if (a < 64) return a / 8;
    if (a < TOTAL) return 8 + (a - 64) / 4;
    return -1;
  endfunction

  function automatic logic [15:0] modelRead(input int a);
    if (mMode == 1) return {8'h00, 8'h80 | mErr};
    if (mMode == 2) return {4'h0, mMask};
    return (a < TOTAL) ? mArr[a] : 16'h0000;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic modelWrite(input int a, input logic [15:0] d, output bit started);
    int s;
    logic [15:0] nv;
    started = 0;
    if (mPhase == 0) begin
      case (d[7:0])
        8'h20: mPhase = 1;
        8'h40: mPhase = 2;
        8'h60: mPhase = 3;
        8'h70: mMode = 1;
        8'h90: mMode = 2;
        8'hFF: mMode = 0;
        8'h50: mErr = 8'h00;
        default: ;
      endcase
    end else begin
      s = secOf(a);
      mMode = 1;
      if (mPhase == 1) begin
        if (d[7:0] != 8'hD0) mErr |= 8'h20;
        else if (s < 0 || mMask[s]) mErr |= 8'h02;
        else begin
          for (int w = 0; w < TOTAL; w++) if (secOf(w) == s) mArr[w] = 16'hFFFF;
          started = 1;
        end
      end else if (mPhase == 2) begin
        if (s < 0 || mMask[s]) mErr |= 8'h02;
        else begin
          nv = mArr[a] & d;
          if (nv != d) mErr |= 8'h10;
          mArr[a] = nv;
          started = 1;
        end
      end else if (s >= 0) begin
        if (d[7:0] == 8'h01) begin mMask[s] = 1'b1; started = 1; end
        else if (d[7:0] == 8'hD0) begin mMask[s] = 1'b0; started = 1; end
      end
      mPhase = 0;
    end
  endtask

  task automatic busWrite(input int a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input int a, output logic [15:0] q);
    @(negedge clk);
    rdEn = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rdEn = 1'b0;
    q = rdData;
  endtask

  task automatic rdCheck(input int a, input string tag);
    logic [15:0] q;
    busRead(a, q);
    check(tag, q, modelRead(a));
  endtask

  // R9: busy status read, then a dropped write, then wait out the window
  task automatic busyProbe();
    logic [15:0] q;
    busRead(0, q);
    check("R9 ready low while busy", q, {8'h00, mErr});
    busWrite(0, 16'h00FF);
    repeat (BUSY_CYCLES + 2) @(negedge clk);
  endtask

  task automatic op(input int a, input logic [15:0] d);
    bit started;
    busWrite(a, d);
    modelWrite(a, d, started);
    if (started) busyProbe();
  endtask

  initial begin
    logic [15:0] q, prev;
    for (int w = 0; w < TOTAL; w++) mArr[w] = 16'hFFFF;
    mMask = '0; mErr = '0; mMode = 0; mPhase = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdCheck(0, "R1 erased word 0");
    rdCheck(79, "R1 erased last word");
    rdCheck(100, "R10 unmapped read is zero");
    op(5, 16'h0090);
    busRead(5, q); check("R1 mask after reset", q, 16'h0000);
    op(5, 16'h0070);
    busRead(5, q); check("R1 status after reset", q, 16'h0080);

    // R3 program and AND behaviour
    op(3, 16'h0040); op(3, 16'h1234);
    busRead(3, q); check("R9 status mode kept after dropped write", q, 16'h0080);
    op(0, 16'h00FF);
    busRead(3, q); check("R3 programmed value", q, 16'h1234);
    op(3, 16'h0040); op(3, 16'h0FFF);
    busRead(3, q); check("R3 program fail flag", q, 16'h0090);
    op(0, 16'h00FF);
    busRead(3, q); check("R3 AND of old and new", q, 16'h0234);

    // R10 registered read timing
    busRead(8, prev);
    @(negedge clk); rdEn = 1'b1; addr = ADDR_W'(3);
    #1 check("R10 no early update", rdData, prev);
    @(negedge clk); rdEn = 1'b0;
    check("R10 value after edge", rdData, 16'h0234);
    @(negedge clk);
    check("R10 holds without rdEn", rdData, 16'h0234);
    op(0, 16'h0011);
    rdCheck(3, "R10 unknown command ignored");

    // R8 clear
    op(0, 16'h0050); op(0, 16'h0070);
    busRead(0, q); check("R8 cleared status", q, 16'h0080);

    // R4 lock layout, R5 locked access
    op(69, 16'h0060); op(69, 16'h0001);
    op(0, 16'h0090);
    busRead(0, q); check("R4 bank 1 sector 1 is mask bit 9", q, 16'h0200);
    op(2, 16'h0060); op(2, 16'h0001);
    rdCheck(0, "R4 mask after bank 0 lock");
    op(69, 16'h0040); op(69, 16'h0000);
    busRead(0, q); check("R5 locked program flagged", q, 16'h0082);
    op(68, 16'h0020); op(68, 16'h00D0);
    rdCheck(0, "R5 locked erase flagged");
    op(0, 16'h00FF);
    rdCheck(69, "R5 locked word unchanged");
    op(100, 16'h0040); op(100, 16'h0000);
    rdCheck(0, "R5 unmapped program flagged");
    op(69, 16'h0060); op(69, 16'h00D0);
    op(0, 16'h0090); rdCheck(0, "R4 lock cleared");

    // R2 erase and R6 bad confirm
    op(8, 16'h0040); op(8, 16'h5555);
    op(1, 16'h0040); op(1, 16'h0F0F);
    op(0, 16'h0020); op(0, 16'h0033);
    rdCheck(0, "R6 bad confirm flagged");
    op(0, 16'h00FF);
    rdCheck(1, "R6 no erase on bad confirm");
    op(6, 16'h0020); op(6, 16'h00D0);
    rdCheck(0, "R7 status after erase confirm");
    op(0, 16'h00FF);
    rdCheck(1, "R2 erased word");
    rdCheck(3, "R2 erased word in same sector");
    rdCheck(8, "R2 neighbour sector untouched");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int a;
      int k;
      a = int'($urandom % 90);
      k = int'($urandom % 8);
      case (k)
        0: begin op(a, 16'h0040); op(a, 16'($urandom)); end
        1: begin op(a, 16'h0020); op(a, ($urandom % 6 == 0) ? 16'h0033 : 16'h00D0); end
        2: begin op(a, 16'h0060); op(a, ($urandom % 2 == 0) ? 16'h0001 : 16'h00D0); end
        3: begin op(a, 16'h0070); rdCheck(a, "R7 random status read"); end
        4: begin op(a, 16'h00FF); rdCheck(a, "R2 random array read"); end
        5: begin op(a, 16'h0090); rdCheck(a, "R4 random mask read"); end
        6: op(a, ($urandom % 2 == 0) ? 16'h0050 : 16'h0011);
        default: rdCheck(a, "R8 random read in current mode");
      endcase
    end

    op(0, 16'h0070); rdCheck(0, "R8 final status");
    op(0, 16'h00FF);
    for (int a = 0; a < 90; a++) rdCheck(a, "R3 final array sweep");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule